// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic/Logic Unit

This block is the execute-stage arithmetic/logic unit of a 32-bit processor, paired with the small decoder that chooses its operation. The main control supplies a 2-bit operation class. Two of the class values force an operation on their own: one for address arithmetic on memory accesses, and one for the equality test of a conditional branch. A third class hands the choice to the 6-bit function field of the instruction word, which register-to-register instructions use. The decoder turns the class and the function field into a 4-bit operation select. The unit then applies that operation to two 32-bit operands.

The block is purely combinational. Its outputs are the result, a zero flag and the operation select itself. The select is exposed so that a neighbouring stage, or a test, can see which operation was picked. Add and subtract wrap around and raise no flag. Set-on-less-than compares the operands as signed numbers. The zero flag is meant for the branch equality test: a subtract of equal operands gives zero.

Top module: `alu_two_level`

## Requirements
- R1: The operation select `op_sel` only ever takes one of six codes: 4'b0000 AND, 4'b0001 OR, 4'b0010 add, 4'b0110 subtract, 4'b0111 set-on-less-than, 4'b1100 NOR.
- R2: With `op_class` = 2'b00 (memory access), `op_sel` is add (4'b0010) and the result is `opnd_a + opnd_b`, whatever `funct` holds.
- R3: With `op_class` = 2'b01 (branch compare), `op_sel` is subtract (4'b0110) and the result is `opnd_a - opnd_b`, whatever `funct` holds.
- R4: With `op_class` = 2'b10 (register-register), `funct` picks the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than, 6'b100111 NOR.
- R5: With `op_class` = 2'b11, or with `op_class` = 2'b10 and any `funct` not listed in R4, `op_sel` is add (4'b0010).
- R6: AND, OR and NOR are bitwise across all 32 bits; NOR is the complement of OR.
- R7: Add and subtract wrap modulo 2^32, with no overflow indication and no effect on any other output.
- R8: Set-on-less-than gives 32'd1 when `opnd_a` is less than `opnd_b` as two's-complement signed values, and 32'd0 otherwise, including the cases where the signed and unsigned orders differ.
- R9: `zero` is 1 exactly when `result` is all zeros, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main control |
| funct | input | 6 | Function field of the instruction word |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | output | 4 | Decoded operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
All 256 combinations of class and function field are swept, each with a fixed set of operand pairs. The sweep separates the forced classes from the deferring one, and the six known function codes from the ones that fall back to add. The operand pairs include equal values, zero, all ones, the most negative and most positive numbers, and sign-mixed pairs. These tell a signed compare apart from an unsigned one, show wraparound at both ends of the range, and make the zero flag rise for subtract and AND as well as for add. A long run of pseudo-random operands under each of the six operations follows.

// File: rtl/alu_pkg.sv
// Package: shared encodings for the two-level decoded ALU.
// Assumes: select codes are fixed because neighbouring logic decodes them.
package alu_pkg;

    typedef enum logic [3:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111,
        SEL_NOR = 4'b1100
    } alu_sel_e;

    localparam logic [1:0] CLS_MEM  = 2'b00;
    localparam logic [1:0] CLS_BRCH = 2'b01;
    localparam logic [1:0] CLS_REG  = 2'b10;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_NOR = 6'b100111;

endpackage

// File: rtl/alu_ctl_decode.sv
// Module: alu_ctl_decode
// Turns the operation class and function field into the 4-bit select.
// Assumes: class 11 and unlisted function codes fall back to add.
module alu_ctl_decode
    import alu_pkg::*;
#(
    parameter int CLS_W = 2,
    parameter int FN_W  = 6
) (
    input  logic [CLS_W-1:0] op_class,
    input  logic [FN_W-1:0]  funct,
    output alu_sel_e         sel
);

    // Purpose: decode the function field for register-register class.
    alu_sel_e fn_sel;
    always_comb begin
        unique case (funct)
            FN_ADD:  fn_sel = SEL_ADD;
            FN_SUB:  fn_sel = SEL_SUB;
            FN_AND:  fn_sel = SEL_AND;
            FN_OR:   fn_sel = SEL_OR;
            FN_SLT:  fn_sel = SEL_SLT;
            FN_NOR:  fn_sel = SEL_NOR;
            default: fn_sel = SEL_ADD;
        endcase
    end

    // Purpose: pick a forced operation or defer to the function field.
    always_comb begin
        case (op_class)
            CLS_MEM:  sel = SEL_ADD;
            CLS_BRCH: sel = SEL_SUB;
            CLS_REG:  sel = fn_sel;
            default:  sel = SEL_ADD;
        endcase
    end

    // Purpose: guard the forced classes and the legal code set.
    always_comb begin
        if (!$isunknown({op_class, funct})) begin
            assert_mem_add_R2: assert (op_class != CLS_MEM || sel == SEL_ADD)
                else $error("memory class did not select add");
            assert_brch_sub_R3: assert (op_class != CLS_BRCH || sel == SEL_SUB)
                else $error("branch class did not select subtract");
            assert_legal_sel_R1: assert (sel inside {SEL_AND, SEL_OR, SEL_ADD,
                                                     SEL_SUB, SEL_SLT, SEL_NOR})
                else $error("illegal select code");
        end
    end

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Applies the selected operation to two operands; add, subtract and
// set-on-less-than share one adder (subtract as a + ~b + 1).
// Assumes: select is one of the six package codes; wraps silently.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_sel_e         sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    localparam int MSB = WIDTH - 1;

    logic             sub_mode;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             ovf;
    logic             less;

    // Purpose: shared adder with inverted second operand for subtract/compare.
    always_comb begin
        sub_mode = (sel == SEL_SUB) || (sel == SEL_SLT);
        b_eff    = sub_mode ? ~b : b;
        sum      = a + b_eff + {{(WIDTH-1){1'b0}}, sub_mode};
        ovf      = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        less     = sum[MSB] ^ ovf;
    end

    // Purpose: choose the result for the current select.
    always_comb begin
        case (sel)
            SEL_AND: y = a & b;
            SEL_OR:  y = a | b;
            SEL_NOR: y = ~(a | b);
            SEL_SLT: y = {{(WIDTH-1){1'b0}}, less};
            default: y = sum;
        endcase
    end

    // Purpose: guard the compare result width and the logic operations.
    always_comb begin
        if (!$isunknown({sel, a, b})) begin
            assert_slt_bool_R8: assert (sel != SEL_SLT || y[MSB:1] == '0)
                else $error("compare result has upper bits set");
            assert_and_subset_R6: assert (sel != SEL_AND || (y & ~a) == '0)
                else $error("AND result has bits outside operand a");
            assert_nor_disjoint_R6: assert (sel != SEL_NOR || (y & (a | b)) == '0)
                else $error("NOR result overlaps an operand");
        end
    end

endmodule

// File: rtl/zero_detect.sv
// Module: zero_detect
// Flags an all-zero word using a two-level tree of chunk ORs.
// Assumes: CHUNK divides the word or the last chunk is narrower.
module zero_detect #(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             is_zero
);

    localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;

    logic [NCHUNK-1:0] chunk_any;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int LO = i * CHUNK;
        localparam int HI = (LO + CHUNK - 1 > WIDTH - 1) ? WIDTH - 1 : LO + CHUNK - 1;
        // Purpose: any bit set within this chunk.
        assign chunk_any[i] = |data[HI:LO];
    end

    // Purpose: combine chunk flags into the final zero flag.
    assign is_zero = ~|chunk_any;

endmodule

// File: rtl/alu_two_level.sv
// Module: alu_two_level (top)
// Two-level decoded ALU: class/function decode, shared-adder core, zero flag.
// Assumes: purely combinational; no overflow reporting.
module alu_two_level
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CLS_W = 2,
    parameter int FN_W  = 6,
    parameter int ZCHUNK = 8
) (
    input  logic [CLS_W-1:0] op_class,
    input  logic [FN_W-1:0]  funct,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    alu_sel_e sel;

    alu_ctl_decode #(.CLS_W(CLS_W), .FN_W(FN_W)) u_dec (
        .op_class (op_class),
        .funct    (funct),
        .sel      (sel)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .sel (sel),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (result)
    );

    zero_detect #(.WIDTH(WIDTH), .CHUNK(ZCHUNK)) u_zero (
        .data    (result),
        .is_zero (zero)
    );

    // Purpose: expose the select as a plain vector.
    assign op_sel = sel;

    // Purpose: relate the zero flag and the subtract of equal operands.
    always_comb begin
        if (!$isunknown({op_class, funct, opnd_a, opnd_b})) begin
            assert_zero_flag_R9: assert (zero == (result == '0))
                else $error("zero flag disagrees with result");
            assert_equal_sub_R3: assert (!(op_class == CLS_BRCH && opnd_a == opnd_b) || zero)
                else $error("equal operands under branch class not zero");
        end
    end

endmodule

// File: tb/sim_alu_two_level.sv
module sim_alu_two_level;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = '0;
    logic [5:0]  funct = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel;
    logic [31:0] result;
    logic        zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    alu_two_level u0 (
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_sel   (op_sel),
        .result   (result),
        .zero     (zero)
    );

    // Reference: operation kind 0 AND, 1 OR, 2 add, 3 sub, 4 slt, 5 nor
    function automatic int ref_kind(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 2;
        if (c == 2'b01) return 3;
        if (c == 2'b11) return 2;
        case (f)
            6'd32: return 2;
            6'd34: return 3;
            6'd36: return 0;
            6'd37: return 1;
            6'd42: return 4;
            6'd39: return 5;
            default: return 2;
        endcase
    endfunction

    function automatic logic [3:0] ref_code(input int k);
        case (k)
            0: return 4'd0;
            1: return 4'd1;
            2: return 4'd2;
            3: return 4'd6;
            4: return 4'd7;
            default: return 4'd12;
        endcase
    endfunction

    function automatic logic [31:0] ref_val(input int k, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (k)
            0: return a & b;
            1: return a | b;
            2: return 32'((longint'(a) + longint'(b)) % 64'h1_0000_0000);
            3: return 32'((longint'(a) - longint'(b) + 64'h1_0000_0000) % 64'h1_0000_0000);
            4: return (sa < sb) ? 32'd1 : 32'd0;
            default: return ~(a | b);
        endcase
    endfunction

    function automatic string sel_tag(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return "R2";
        if (c == 2'b01) return "R3";
        if (c == 2'b11) return "R5";
        if (f inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd39}) return "R4";
        return "R5";
    endfunction

    function automatic string val_tag(input int k);
        if (k == 0 || k == 1 || k == 5) return "R6";
        if (k == 4) return "R8";
        return "R7";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (class %b funct %b a %h b %h)",
                     tag, what, act, exp, op_class, funct, opnd_a, opnd_b);
        end
    endtask

    // Drive after a rising edge, compare against the model at the falling edge.
    task automatic run_vec(input logic [1:0] c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        int k;
        logic [31:0] ev;
        @(posedge clk);
        #1;
        op_class = c; funct = f; opnd_a = a; opnd_b = b;
        k  = ref_kind(c, f);
        ev = ref_val(k, a, b);
        @(negedge clk);
        check(sel_tag(c, f), "select", {28'd0, op_sel}, {28'd0, ref_code(k)});
        check(val_tag(k), "result", result, ev);
        check("R9", "zero", {31'd0, zero}, {31'd0, (ev == 32'd0)});
    endtask

    logic [31:0] pa [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                            32'h1234_5678, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0005};
    logic [31:0] pb [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                            32'h1234_5678, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFB};

    initial begin : stim
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state, all inputs zero: add of zeros
        @(negedge clk);
        check("R2", "reset select", {28'd0, op_sel}, 32'd2);
        check("R9", "reset zero", {31'd0, zero}, 32'd1);
        check("R2", "reset result", result, 32'd0);

        // R1: each code value of the select, directed
        run_vec(2'b10, 6'd36, 32'hF0F0_F0F0, 32'hFF00_FF00);
        check("R1", "AND code", {28'd0, op_sel}, 32'h0);
        run_vec(2'b10, 6'd37, 32'hF0F0_F0F0, 32'h0F00_0000);
        check("R1", "OR code", {28'd0, op_sel}, 32'h1);
        run_vec(2'b10, 6'd42, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R8", "signed -1 < 1", result, 32'd1);
        check("R1", "SLT code", {28'd0, op_sel}, 32'h7);
        run_vec(2'b10, 6'd39, 32'h0000_0000, 32'h0000_0000);
        check("R6", "NOR of zeros", result, 32'hFFFF_FFFF);
        check("R1", "NOR code", {28'd0, op_sel}, 32'hC);
        run_vec(2'b01, 6'd37, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        check("R3", "branch equal zero", {31'd0, zero}, 32'd1);
        check("R1", "SUB code", {28'd0, op_sel}, 32'h6);
        run_vec(2'b00, 6'd34, 32'hFFFF_FFFF, 32'h0000_0002);
        check("R7", "add wraps", result, 32'h0000_0001);

        // Full sweep of class and function field over boundary operands
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 64; f++)
                for (int p = 0; p < 8; p++)
                    run_vec(2'(c), 6'(f), pa[p], pb[p]);

        // Pseudo-random operands under each register-register operation
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] fsel [6] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd39};
            run_vec(2'b10, fsel[i % 6], $urandom, $urandom);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        #1_500_000ns;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule